// File: doc/BRIEF.md
# Register Write-Pending Hazard Scoreboard

This block tracks which registers of one register file still have a write outstanding. Each register owns one pending bit. A bit goes high when an instruction that names that register as its destination is issued to a function unit. It goes low again when a granted write-port access lands on that register, or when the unit finishes without ever producing a write. Issue logic reads the vector to hold back instructions. Each read-check port compares a requested source register against the vector and raises a read-after-write hazard. Each unit's issue slot compares its destination against the vector and raises a write-after-write hazard.

The pending bit is set one clock after the issue event. An instruction whose source and destination are the same register therefore never blocks itself. Several write ports and several units feed the same vector. All their set masks are merged into one mask, and all their clear masks into another, before the vector is updated. Register numbers arrive either as binary indices or, when the `UNARY` parameter is set, already in one-hot form. Units flagged as load/store never use the no-write clear, because they always deliver a write.

Top module: `hz_scoreboard`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, the pending vector is all zeros and no hazard output is high.
- R2: Issuing a writing instruction to a unit with binary destination n sets bit n of `pend_vec`. The bit is still low in the issue cycle and in the following cycle. It is high after the second rising edge counted from the issue cycle.
- R3: A granted write port carrying binary register n clears bit n of `pend_vec` at the next rising edge.
- R4: Several units issuing in the same cycle, and several write ports granted in the same cycle, all take effect together. Their masks are merged by OR.
- R5: When a set and a clear reach the same bit in the same cycle, the bit ends up set.
- R6: `raw_hazard[c]` is high exactly when `chk_req[c]` is high, the check is not retired, and `pend_vec` has the bit of `chk_reg[c]` set.
- R7: A check port retires at the next edge after a cycle in which `chk_busy[c]` and `chk_req[c]` are high and no hazard is seen. While retired it reports no hazard, even if the bit later becomes set. It re-arms at the next edge after `chk_busy[c]` goes low.
- R8: `waw_hazard[u]` is high exactly when `iss_wr[u]` is high and `pend_vec` has the bit of unit u's destination set. `iss_valid` does not gate it.
- R9: A unit that signals `unit_done` with `unit_out_ok` low, while its latched write flag is high, clears its latched destination bit at the next edge. With `unit_out_ok` high, done leaves the bit alone.
- R10: A unit's latched write flag is captured at issue and drops to zero on any edge where the unit is not busy. A later done with `unit_out_ok` low then clears nothing.
- R11: Units whose bit is set in `LDST_MASK` never use the no-write clear (default: unit 2).
- R12: Issuing with `iss_wr` low sets no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | NUNITS | Issue event per unit |
| iss_wr | input | NUNITS | Issued instruction writes a register |
| iss_dst | input | NUNITS*RW | Destination register per unit (binary or one-hot) |
| unit_busy | input | NUNITS | Unit is occupied |
| unit_done | input | NUNITS | Unit finished its operation |
| unit_out_ok | input | NUNITS | Unit's result carries a valid write |
| wp_grant | input | NWPORTS | Write port access granted this cycle |
| wp_reg | input | NWPORTS*RW | Register written by each port |
| chk_req | input | NCHK | Read check requested |
| chk_busy | input | NCHK | Unit owning the check is busy |
| chk_reg | input | NCHK*RW | Source register to check |
| pend_vec | output | NREGS | Pending-write vector |
| raw_hazard | output | NCHK | Read-after-write hazard per check port |
| waw_hazard | output | NUNITS | Write-after-write hazard per unit |

## Verification
The bench issues to one unit at a time, and to two units in the same cycle. It samples the vector in each of the three cycles around an issue, which separates a set that lands too early from one that lands correctly one clock late. It clears through a single write port and through two ports at once, and drives a set and a clear onto one bit together to confirm the set wins. It then walks the no-write path with the output-valid flag high and low, with the unit going idle between issue and done, and on a load/store unit. Finally it drives a check port through its retire and re-arm sequence against a bit that becomes pending after retirement.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int MAX_REGS = 64;
  localparam int IDX_W    = 7;

  // binary register index -> one-hot mask (upper part unused for small files)
  function automatic logic [MAX_REGS-1:0] bin_onehot(input logic [IDX_W-1:0] idx);
    logic [MAX_REGS-1:0] m;
    m = '0;
    if (idx < IDX_W'(MAX_REGS)) m[idx[5:0]] = 1'b1;
    return m;
  endfunction

  // any overlap between pending vector and a request mask
  function automatic logic mask_hit(input logic [MAX_REGS-1:0] vec,
                                    input logic [MAX_REGS-1:0] req);
    return |(vec & req);
  endfunction
endpackage

// File: rtl/hz_decode.sv
module hz_decode #(
  parameter int NREGS = 32,
  parameter bit UNARY = 1'b0,
  parameter int RW    = UNARY ? NREGS : $clog2(NREGS)
) (
  input  logic [RW-1:0]    reg_i,
  output logic [NREGS-1:0] mask_o
);
  generate
    if (UNARY) begin : g_unary
      assign mask_o = NREGS'(reg_i);
    end else begin : g_binary
      logic [hz_pkg::MAX_REGS-1:0] wide;
      assign wide   = hz_pkg::bin_onehot(hz_pkg::IDX_W'(reg_i));
      assign mask_o = wide[NREGS-1:0];
    end
  endgenerate
endmodule

// File: rtl/hz_unit.sv
module hz_unit #(
  parameter int NREGS   = 32,
  parameter bit IS_LDST = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  logic             iss_wr,
  input  logic [NREGS-1:0] iss_mask,
  input  logic             busy,
  input  logic             done,
  input  logic             out_ok,
  output logic [NREGS-1:0] set_mask_o,
  output logic [NREGS-1:0] clr_mask_o,
  output logic             nowr_clr_o
);
  logic             issue_d;
  logic [NREGS-1:0] dst_hold;
  logic             wr_latch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issue_d  <= 1'b0;
      dst_hold <= '0;
      wr_latch <= 1'b0;
    end else begin
      issue_d <= iss_valid & iss_wr;
      if (iss_valid) dst_hold <= iss_mask;
      if (iss_valid)  wr_latch <= iss_wr;
      else if (!busy) wr_latch <= 1'b0;
    end
  end

  assign nowr_clr_o = (IS_LDST == 1'b0) & done & wr_latch & ~out_ok;
  assign set_mask_o = issue_d    ? dst_hold : '0;
  assign clr_mask_o = nowr_clr_o ? dst_hold : '0;
endmodule

// File: rtl/hz_check.sv
module hz_check #(
  parameter int NREGS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             busy,
  input  logic [NREGS-1:0] mask,
  input  logic [NREGS-1:0] vec,
  output logic             hazard_o
);
  logic retired;
  logic hit;

  assign hit      = hz_pkg::mask_hit(hz_pkg::MAX_REGS'(vec), hz_pkg::MAX_REGS'(mask));
  assign hazard_o = req & ~retired & hit;

  always_ff @(posedge clk) begin
    if (!rst_n)                  retired <= 1'b0;
    else if (!busy)              retired <= 1'b0;
    else if (req && !hazard_o)   retired <= 1'b1;
  end
endmodule

// File: rtl/hz_scoreboard.sv
module hz_scoreboard #(
  parameter int NREGS             = 32,
  parameter int NUNITS            = 3,
  parameter int NWPORTS           = 2,
  parameter int NCHK              = 2,
  parameter bit UNARY             = 1'b0,
  parameter logic [NUNITS-1:0] LDST_MASK = 3'b100,
  parameter int RW                = UNARY ? NREGS : $clog2(NREGS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUNITS-1:0]       iss_valid,
  input  logic [NUNITS-1:0]       iss_wr,
  input  logic [NUNITS*RW-1:0]    iss_dst,
  input  logic [NUNITS-1:0]       unit_busy,
  input  logic [NUNITS-1:0]       unit_done,
  input  logic [NUNITS-1:0]       unit_out_ok,
  input  logic [NWPORTS-1:0]      wp_grant,
  input  logic [NWPORTS*RW-1:0]   wp_reg,
  input  logic [NCHK-1:0]         chk_req,
  input  logic [NCHK-1:0]         chk_busy,
  input  logic [NCHK*RW-1:0]      chk_reg,
  output logic [NREGS-1:0]        pend_vec,
  output logic [NCHK-1:0]         raw_hazard,
  output logic [NUNITS-1:0]       waw_hazard
);
  logic [NREGS-1:0] unit_set [NUNITS];
  logic [NREGS-1:0] unit_clr [NUNITS];
  logic [NREGS-1:0] wp_clr   [NWPORTS];
  logic [NREGS-1:0] set_all;
  logic [NREGS-1:0] clr_all;
  logic [NUNITS-1:0] nowr_clr;

  generate
    for (genvar u = 0; u < NUNITS; u++) begin : g_unit
      logic [NREGS-1:0] dmask;
      hz_decode #(.NREGS(NREGS), .UNARY(UNARY), .RW(RW)) u_dec (
        .reg_i (iss_dst[u*RW +: RW]),
        .mask_o(dmask)
      );
      hz_unit #(.NREGS(NREGS), .IS_LDST(LDST_MASK[u])) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .iss_valid (iss_valid[u]),
        .iss_wr    (iss_wr[u]),
        .iss_mask  (dmask),
        .busy      (unit_busy[u]),
        .done      (unit_done[u]),
        .out_ok    (unit_out_ok[u]),
        .set_mask_o(unit_set[u]),
        .clr_mask_o(unit_clr[u]),
        .nowr_clr_o(nowr_clr[u])
      );
      assign waw_hazard[u] = iss_wr[u] &
        hz_pkg::mask_hit(hz_pkg::MAX_REGS'(pend_vec), hz_pkg::MAX_REGS'(dmask));
    end

    for (genvar p = 0; p < NWPORTS; p++) begin : g_wport
      logic [NREGS-1:0] wmask;
      hz_decode #(.NREGS(NREGS), .UNARY(UNARY), .RW(RW)) u_dec (
        .reg_i (wp_reg[p*RW +: RW]),
        .mask_o(wmask)
      );
      assign wp_clr[p] = wp_grant[p] ? wmask : '0;
    end

    for (genvar c = 0; c < NCHK; c++) begin : g_chk
      logic [NREGS-1:0] cmask;
      hz_decode #(.NREGS(NREGS), .UNARY(UNARY), .RW(RW)) u_dec (
        .reg_i (chk_reg[c*RW +: RW]),
        .mask_o(cmask)
      );
      hz_check #(.NREGS(NREGS)) u_chk (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (chk_req[c]),
        .busy    (chk_busy[c]),
        .mask    (cmask),
        .vec     (pend_vec),
        .hazard_o(raw_hazard[c])
      );
    end
  endgenerate

  // merge every source of set and clear into one mask each
  always_comb begin
    set_all = '0;
    clr_all = '0;
    for (int u = 0; u < NUNITS; u++) begin
      set_all = set_all | unit_set[u];
      clr_all = clr_all | unit_clr[u];
    end
    for (int p = 0; p < NWPORTS; p++) clr_all = clr_all | wp_clr[p];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_vec <= '0;
    else        pend_vec <= (pend_vec & ~clr_all) | set_all;
  end
endmodule

// File: rtl/hz_scoreboard_chk.sv
module hz_scoreboard_chk #(
  parameter int NREGS   = 32,
  parameter int NUNITS  = 3,
  parameter int NCHK    = 2,
  parameter logic [NUNITS-1:0] LDST_MASK = 3'b100
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NREGS-1:0]  pend_vec,
  input logic [NREGS-1:0]  set_all,
  input logic [NREGS-1:0]  clr_all,
  input logic [NUNITS-1:0] nowr_clr,
  input logic [NUNITS-1:0] unit_done,
  input logic [NUNITS-1:0] iss_wr,
  input logic [NUNITS-1:0] waw_hazard,
  input logic [NCHK-1:0]   chk_req,
  input logic [NCHK-1:0]   raw_hazard
);
  p_reset_zero_r1: assert property (@(posedge clk) !rst_n |=> (pend_vec == '0));

  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_all != '0) |=> ((pend_vec & $past(set_all)) == $past(set_all)));

  p_clear_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_all & ~set_all) != '0) |=> ((pend_vec & $past(clr_all & ~set_all)) == '0));

  p_quiet_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_all | clr_all) == '0) |=> $stable(pend_vec));

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_all & clr_all) != '0) |=>
      ((pend_vec & $past(set_all & clr_all)) == $past(set_all & clr_all)));

  p_raw_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_hazard & ~chk_req) == '0));

  p_waw_needs_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((waw_hazard & ~iss_wr) == '0));

  p_nowr_needs_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((nowr_clr & ~unit_done) == '0));

  p_ldst_no_nowr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((nowr_clr & LDST_MASK) == '0));
endmodule

bind hz_scoreboard hz_scoreboard_chk #(
  .NREGS(NREGS), .NUNITS(NUNITS), .NCHK(NCHK), .LDST_MASK(LDST_MASK)
) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .pend_vec  (pend_vec),
  .set_all   (set_all),
  .clr_all   (clr_all),
  .nowr_clr  (nowr_clr),
  .unit_done (unit_done),
  .iss_wr    (iss_wr),
  .waw_hazard(waw_hazard),
  .chk_req   (chk_req),
  .raw_hazard(raw_hazard)
);

// File: tb/hz_scoreboard_test.sv
module hz_scoreboard_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREGS = 32;
  localparam int NU    = 3;
  localparam int NWP   = 2;
  localparam int NC    = 2;
  localparam int RW    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NU-1:0]     iss_valid = '0, iss_wr = '0, unit_busy = '0, unit_done = '0, unit_out_ok = '0;
  logic [NU*RW-1:0]  iss_dst = '0;
  logic [NWP-1:0]    wp_grant = '0;
  logic [NWP*RW-1:0] wp_reg = '0;
  logic [NC-1:0]     chk_req = '0, chk_busy = '0;
  logic [NC*RW-1:0]  chk_reg = '0;
  logic [NREGS-1:0]  pend_vec;
  logic [NC-1:0]     raw_hazard;
  logic [NU-1:0]     waw_hazard;

  always #(CLK_PERIOD/2) clk = ~clk;

  hz_scoreboard uut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_wr(iss_wr), .iss_dst(iss_dst),
    .unit_busy(unit_busy), .unit_done(unit_done), .unit_out_ok(unit_out_ok),
    .wp_grant(wp_grant), .wp_reg(wp_reg), .chk_req(chk_req), .chk_busy(chk_busy),
    .chk_reg(chk_reg), .pend_vec(pend_vec), .raw_hazard(raw_hazard), .waw_hazard(waw_hazard)
  );

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // monitor: compares every queued expectation half a cycle after the edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = pend_vec;
        1:       act = 32'(raw_hazard);
        default: act = 32'(waw_hazard);
      endcase
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask
  task automatic expv(input logic [31:0] e, input string t); q.push_back('{0, e, t}); endtask
  task automatic expr(input logic [31:0] e, input string t); q.push_back('{1, e, t}); endtask
  task automatic expw(input logic [31:0] e, input string t); q.push_back('{2, e, t}); endtask

  task automatic issue(input int u, input int d, input logic wr);
    iss_valid[u] = 1'b1; iss_wr[u] = wr; iss_dst[u*RW +: RW] = RW'(d);
  endtask
  task automatic grant(input int p, input int r);
    wp_grant[p] = 1'b1; wp_reg[p*RW +: RW] = RW'(r);
  endtask
  task automatic idle_in();
    iss_valid = '0; iss_wr = '0; wp_grant = '0;
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    expv(0, "R1 vector after reset"); expr(0, "R1 raw after reset"); expw(0, "R1 waw after reset");
    cyc();

    // R2: set lands two edges after the issue cycle
    unit_busy[0] = 1'b1;
    issue(0, 5, 1'b1); expv(0, "R2 issue cycle"); cyc();
    idle_in();         expv(0, "R2 one edge later"); cyc();
    expv(32'h1 << 5, "R2 bit set"); cyc();

    // R8: waw check from the destination, ungated by issue
    iss_wr[1] = 1'b1; iss_dst[1*RW +: RW] = 5; expw(3'b010, "R8 match"); cyc();
    iss_dst[1*RW +: RW] = 6; expw(0, "R8 miss"); cyc();
    iss_wr[1] = 1'b0;

    // R6: raw check
    chk_req[0] = 1'b1; chk_reg[0 +: RW] = 5; expr(2'b01, "R6 hit"); cyc();
    chk_reg[0 +: RW] = 4; expr(0, "R6 other reg"); cyc();
    chk_req[0] = 1'b0; chk_reg[0 +: RW] = 5; expr(0, "R6 no request"); cyc();

    // R3: single port clear
    grant(0, 5); expv(32'h1 << 5, "R3 before clear"); cyc();
    idle_in();   expv(0, "R3 cleared"); cyc();

    // R4: two units set, two ports clear in one cycle
    issue(0, 3, 1'b1); issue(1, 9, 1'b1); cyc();
    idle_in(); cyc();
    grant(0, 3); grant(1, 9); expv((32'h1 << 3) | (32'h1 << 9), "R4 both set"); cyc();
    idle_in(); expv(0, "R4 both cleared"); cyc();

    // R5: set and clear on one bit
    issue(1, 12, 1'b1); cyc();
    idle_in(); grant(0, 12); cyc();
    idle_in(); expv(32'h1 << 12, "R5 set wins"); cyc();
    grant(0, 12); cyc();
    idle_in(); expv(0, "R5 cleanup"); cyc();

    // R12: non-writing issue
    issue(1, 20, 1'b0); cyc();
    idle_in(); cyc();
    expv(0, "R12 no set"); cyc();

    // R7: retire then re-arm
    chk_req[1] = 1'b1; chk_busy[1] = 1'b1; chk_reg[1*RW +: RW] = 7;
    issue(1, 7, 1'b1); expr(0, "R7 no hazard while busy"); cyc();
    idle_in(); cyc();
    expv(32'h1 << 7, "R7 bit pending"); expr(0, "R7 retired"); cyc();
    chk_busy[1] = 1'b0; expr(0, "R7 still retired"); cyc();
    expr(2'b10, "R7 re-armed"); cyc();
    chk_req[1] = 1'b0; grant(0, 7); cyc();
    idle_in(); expv(0, "R7 cleanup"); cyc();

    // R9: no-write clear
    issue(0, 14, 1'b1); cyc();
    idle_in(); cyc();
    expv(32'h1 << 14, "R9 set"); unit_done[0] = 1'b1; unit_out_ok[0] = 1'b1; cyc();
    unit_done[0] = 1'b0; unit_out_ok[0] = 1'b0; expv(32'h1 << 14, "R9 valid output keeps bit"); cyc();
    unit_done[0] = 1'b1; cyc();
    unit_done[0] = 1'b0; expv(0, "R9 no-write clear"); cyc();

    // R10: flag dropped while idle
    issue(0, 6, 1'b1); cyc();
    idle_in(); cyc();
    unit_busy[0] = 1'b0; expv(32'h1 << 6, "R10 set"); cyc();
    unit_busy[0] = 1'b1; unit_done[0] = 1'b1; cyc();
    unit_done[0] = 1'b0; expv(32'h1 << 6, "R10 flag dropped, no clear"); cyc();
    grant(1, 6); cyc();
    idle_in(); expv(0, "R10 cleanup"); cyc();

    // R11: load/store unit never uses the no-write clear
    unit_busy[2] = 1'b1;
    issue(2, 8, 1'b1); cyc();
    idle_in(); cyc();
    expv(32'h1 << 8, "R11 set"); unit_done[2] = 1'b1; cyc();
    unit_done[2] = 1'b0; expv(32'h1 << 8, "R11 ldst keeps bit"); cyc();

    @(negedge clk); #1;
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule